// File: doc/BRIEF.md
# Single-Precision Float to Integer Converter

This block turns a binary32 floating-point operand into a 32-bit integer, either unsigned or two's-complement signed, chosen per operation by a mode input. The integer is rounded under one of four rounding directions. A truncate input overrides the direction and forces rounding toward zero.

Alongside the integer, the block reports three flags:
- **invalid**: the value could not be represented.
- **inexact**: fraction bits were discarded.
- **in_denorm**: the operand was subnormal.

Values out of range and NaNs saturate to fixed codes. Those codes, and the conditions that raise invalid, differ between the signed and unsigned modes and depend on the operand's sign. The conversion is one registered stage: the outputs present the operation sampled at the previous rising clock edge.

Top module: `fp32_to_int_cvt`

## Requirements
- R1: While rst_n is low, all outputs are zero. After reset, each output shows the conversion of the inputs sampled at the previous rising clock edge.
- R2: rmode encoding: 0 is nearest with ties to even, 1 is toward +infinity, 2 is toward -infinity, 3 is toward zero. When trunc is 1, rmode is ignored and rounding is toward zero.
- R3: For biased exponents 126 to 158, the result is the value rounded to an integer in the selected direction.
- R4: inexact is 1 when the rounded result is delivered without saturation or invalid, and discarded fraction bits were nonzero.
- R5: in_denorm is 1 exactly when the exponent field (bits 30:23) is zero and the fraction field (bits 22:0) is nonzero.
- R6: For a biased exponent of 159 or more on a non-NaN operand, invalid is raised. Unsigned mode gives 0xFFFFFFFF for a positive operand and 0 for a negative one. Signed mode gives 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one.
- R7: A NaN (exponent 255, fraction nonzero) gives 0 with invalid in signed mode. In unsigned mode its sign is disregarded and it gives 0xFFFFFFFF with invalid.
- R8: In unsigned mode, a negative operand whose rounded magnitude is nonzero gives 0 with invalid and no inexact.
- R9: In signed mode, a rounded magnitude above 0x7FFFFFFF (positive) or above 0x80000000 (negative) clamps to that limit with invalid and without inexact. Otherwise negative operands return the two's complement of the magnitude.
- R10: For biased exponents below 126, the result is 0, and a nonzero operand raises inexact. The directed modes change this as follows:
  - Toward +infinity on a positive operand gives 1.
  - Toward -infinity on a negative operand gives 0xFFFFFFFF in signed mode, or 0 with invalid in unsigned mode.
- R11: Positive and negative zero give 0 with no flag raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| f | input | 32 | binary32 operand |
| is_signed | input | 1 | 1 selects a signed result, 0 selects an unsigned result |
| rmode | input | 2 | Rounding direction, encoded as in R2 |
| trunc | input | 1 | Forces rounding toward zero |
| result | output | 32 | Converted integer |
| invalid | output | 1 | Operand not representable |
| inexact | output | 1 | Discarded fraction was nonzero |
| in_denorm | output | 1 | Operand was subnormal |

## Verification
The bench builds the block with its default parameters: a registered output stage and binary32 fields converted to a 32-bit integer. At this size every exponent boundary can be driven directly:
- 125 and 126 for the sub-one rule.
- 158 for the signed clamp at 2^31.
- 159 for saturation.
- 255 for NaN and infinity.

Directed operands place exact ties, results of -2^31 and subnormals on the decision points. A stream of random operands is concentrated on exponents 100 to 170, so rounding carries and the signed and unsigned limits are reached in all four directions.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int INT_W  = 32;
  localparam int FP_W   = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int PAD_W  = INT_W - FRAC_W - 1;
  localparam int EXP_LO  = BIAS - 1;          // below: magnitude under one half
  localparam int EXP_TOP = BIAS + INT_W - 1;  // shift of zero
  localparam int EXP_SAT = BIAS + INT_W;      // at or above: saturate
  localparam int SH_W    = $clog2(INT_W + 1);

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_UP   = 2'd1,
    RND_DOWN = 2'd2,
    RND_ZERO = 2'd3
  } rnd_e;

  typedef enum logic [1:0] {
    RANGE_SMALL = 2'd0,
    RANGE_MID   = 2'd1,
    RANGE_BIG   = 2'd2
  } range_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [INT_W-1:0] word;
    logic             is_nan;
    logic             is_denorm;
    logic             nonzero;
  } opnd_t;
endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
  import fcvt_pkg::*;
(
  input  logic [FP_W-1:0] f,
  input  logic            is_signed,
  output opnd_t           op
);
  logic [EXP_W-1:0]  e_fld;
  logic [FRAC_W-1:0] m_fld;
  logic              e_zero;
  logic              e_ones;
  logic              nan_w;

  always_comb begin
    e_fld = f[FP_W-2:FRAC_W];
    m_fld = f[FRAC_W-1:0];
    e_zero = (e_fld == '0);
    e_ones = &e_fld;
    nan_w  = e_ones && (m_fld != '0);
    op.is_nan    = nan_w;
    op.is_denorm = e_zero && (m_fld != '0);
    op.nonzero   = (f[FP_W-2:0] != '0);
    // unsigned conversion treats every NaN as positive
    op.sign = f[FP_W-1] & ~(nan_w & ~is_signed);
    op.exp  = e_fld;
    // hidden bit at the top of the word
    op.word = {~e_zero, m_fld, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
  import fcvt_pkg::*;
(
  input  logic [EXP_W-1:0] exp,
  input  logic [INT_W-1:0] word,
  output range_e           range,
  output logic [INT_W-1:0] int_part,
  output logic [INT_W-1:0] rem
);
  localparam logic [EXP_W:0] SAT_E = (EXP_W + 1)'(EXP_SAT);
  localparam logic [EXP_W:0] LO_E  = (EXP_W + 1)'(EXP_LO);
  localparam logic [EXP_W:0] TOP_E = (EXP_W + 1)'(EXP_TOP);

  logic [EXP_W:0]     exp_x;
  logic [SH_W-1:0]    shift;
  logic [2*INT_W-1:0] wide;

  always_comb begin
    exp_x = {1'b0, exp};
    shift = '0;
    if (exp_x >= SAT_E) begin
      range = RANGE_BIG;
    end else if (exp_x >= LO_E) begin
      range = RANGE_MID;
      shift = SH_W'(TOP_E - exp_x);
    end else begin
      range = RANGE_SMALL;
    end
    // upper half: integer part, lower half: left-aligned discarded bits
    wide     = {word, {INT_W{1'b0}}} >> shift;
    int_part = wide[2*INT_W-1:INT_W];
    rem      = wide[INT_W-1:0];
  end
endmodule

// File: rtl/fcvt_round_sat.sv
module fcvt_round_sat
  import fcvt_pkg::*;
(
  input  range_e           range,
  input  logic [INT_W-1:0] int_part,
  input  logic [INT_W-1:0] rem,
  input  logic             sign,
  input  logic             is_nan,
  input  logic             nonzero,
  input  logic             is_signed,
  input  rnd_e             mode,
  output logic [INT_W-1:0] res,
  output logic             inv,
  output logic             inx
);
  logic [INT_W-1:0] incr;
  logic [INT_W-1:0] sum;
  logic             carry;
  logic             int_full;
  logic [INT_W-1:0] bumped;
  logic [INT_W-1:0] lim;

  always_comb begin
    unique case (mode)
      RND_NEAR: incr = {1'b1, {(INT_W-1){1'b0}}} - {{(INT_W-1){1'b0}}, ~int_part[0]};
      RND_UP:   incr = sign ? '0 : '1;
      RND_DOWN: incr = sign ? '1 : '0;
      default:  incr = '0;
    endcase
    sum      = rem + incr;
    carry    = (sum < rem);
    int_full = &int_part;
    bumped   = int_part + {{(INT_W-1){1'b0}}, carry & ~int_full};
    lim      = {sign, {(INT_W-1){~sign}}};

    res = '0;
    inv = 1'b0;
    inx = 1'b0;
    if (is_signed && is_nan) begin
      inv = 1'b1;
    end else begin
      unique case (range)
        RANGE_BIG: begin
          inv = 1'b1;
          if (is_signed) res = lim;
          else           res = sign ? '0 : '1;
        end
        RANGE_MID: begin
          if (!is_signed) begin
            inv = carry & int_full;
            if (sign && (bumped != '0)) begin
              inv = 1'b1;
            end else begin
              res = bumped;
              inx = (rem != '0);
            end
          end else if (bumped > lim) begin
            res = lim;
            inv = 1'b1;
          end else begin
            res = sign ? -bumped : bumped;
            inx = (rem != '0);
          end
        end
        default: begin
          if (nonzero) begin
            inx = 1'b1;
            if (mode == RND_UP && !sign) begin
              res = {{(INT_W-1){1'b0}}, 1'b1};
            end else if (mode == RND_DOWN && sign) begin
              if (is_signed) res = '1;
              else           inv = 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fp32_to_int_cvt.sv
module fp32_to_int_cvt
  import fcvt_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] f,
  input  logic        is_signed,
  input  logic [1:0]  rmode,
  input  logic        trunc,
  output logic [31:0] result,
  output logic        invalid,
  output logic        inexact,
  output logic        in_denorm
);
  opnd_t            op;
  range_e           range;
  rnd_e             mode;
  logic [INT_W-1:0] int_part;
  logic [INT_W-1:0] rem;
  logic [INT_W-1:0] res_d;
  logic             inv_d;
  logic             inx_d;

  always_comb mode = trunc ? RND_ZERO : rnd_e'(rmode);

  fcvt_classify u_cls (
    .f         (f),
    .is_signed (is_signed),
    .op        (op)
  );

  fcvt_align u_aln (
    .exp      (op.exp),
    .word     (op.word),
    .range    (range),
    .int_part (int_part),
    .rem      (rem)
  );

  fcvt_round_sat u_rs (
    .range     (range),
    .int_part  (int_part),
    .rem       (rem),
    .sign      (op.sign),
    .is_nan    (op.is_nan),
    .nonzero   (op.nonzero),
    .is_signed (is_signed),
    .mode      (mode),
    .res       (res_d),
    .inv       (inv_d),
    .inx       (inx_d)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          invalid   <= 1'b0;
          inexact   <= 1'b0;
          in_denorm <= 1'b0;
        end else begin
          result    <= res_d;
          invalid   <= inv_d;
          inexact   <= inx_d;
          in_denorm <= op.is_denorm;
        end
      end
    end else begin : g_comb
      assign result    = res_d;
      assign invalid   = inv_d;
      assign inexact   = inx_d;
      assign in_denorm = op.is_denorm;
    end
  endgenerate
endmodule

// File: rtl/fcvt_checker.sv
module fcvt_checker
  import fcvt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] f,
  input logic        is_signed,
  input logic [31:0] result,
  input logic        invalid,
  input logic        inexact,
  input logic        in_denorm
);
  logic [EXP_W-1:0]  e_fld;
  logic [FRAC_W-1:0] m_fld;
  logic              nan_in;
  logic              sub_in;

  always_comb begin
    e_fld  = f[FP_W-2:FRAC_W];
    m_fld  = f[FRAC_W-1:0];
    nan_in = (&e_fld) && (m_fld != '0);
    sub_in = (e_fld == '0) && (m_fld != '0);
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RST_CLEAR: assert (result == '0 && !invalid && !inexact && !in_denorm); // R1
    end
  end

  AST_DENORM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sub_in |=> in_denorm); // R5
  AST_DENORM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_in |=> !in_denorm); // R5
  AST_BIG_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, e_fld} >= (EXP_W + 1)'(EXP_SAT)) |=> invalid); // R6
  AST_SIGNED_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_signed && nan_in) |=> (result == '0 && invalid)); // R7
  AST_UNSIGNED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_signed && f[FP_W-1] && !nan_in) |=> (result == '0)); // R8
  AST_CLAMP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_signed |=> !(invalid && inexact)); // R9
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (f[FP_W-2:0] == '0) |=> (result == '0 && !invalid && !inexact)); // R11
endmodule

bind fp32_to_int_cvt fcvt_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .f         (f),
  .is_signed (is_signed),
  .result    (result),
  .invalid   (invalid),
  .inexact   (inexact),
  .in_denorm (in_denorm)
);

// File: tb/sim_fp32_to_int_cvt.sv
`timescale 1ns/1ps
module sim_fp32_to_int_cvt;
  logic        clk;
  logic        rst_n;
  logic [31:0] f;
  logic        is_signed;
  logic [1:0]  rmode;
  logic        trunc;
  logic [31:0] result;
  logic        invalid;
  logic        inexact;
  logic        in_denorm;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "idle";
  logic [34:0] exp_q[$];
  string       tag_q[$];

  fp32_to_int_cvt u0 (
    .clk(clk), .rst_n(rst_n), .f(f), .is_signed(is_signed), .rmode(rmode),
    .trunc(trunc), .result(result), .invalid(invalid), .inexact(inexact),
    .in_denorm(in_denorm)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference: {result, invalid, inexact, in_denorm}
  function automatic logic [34:0] ref_cvt(input logic [31:0] x, input logic sm,
                                          input logic [1:0] rm_in, input logic tr);
    int e, rm, k;
    longint mant, q, r, half, lim;
    logic neg, nan, den, any, up, inv, inx;
    logic [31:0] res;
    e = int'(x[30:23]);
    neg = x[31];
    nan = (e == 255) && (x[22:0] != 0);
    den = (e == 0) && (x[22:0] != 0);
    rm = tr ? 3 : int'(rm_in);
    res = 0; inv = 0; inx = 0; any = 0; up = 0;
    mant = (e == 0) ? longint'(x[22:0]) : longint'(x[22:0]) + (64'd1 << 23);
    if (nan && sm) begin
      inv = 1;
    end else begin
      if (nan) neg = 0;
      if (e >= 159) begin
        inv = 1;
        if (sm) res = neg ? 32'h8000_0000 : 32'h7fff_ffff;
        else    res = neg ? 32'h0 : 32'hffff_ffff;
      end else if (e >= 126) begin
        if (e >= 150) begin
          q = mant << (e - 150);
        end else begin
          k = 150 - e;
          q = mant >> k;
          r = mant & ((64'd1 << k) - 1);
          half = 64'd1 << (k - 1);
          any = (r != 0);
          case (rm)
            0: up = (r > half) || (r == half && q[0]);
            1: up = any && !neg;
            2: up = any && neg;
            default: up = 0;
          endcase
        end
        if (up) q = q + 1;
        if (!sm) begin
          if (neg && q != 0) inv = 1;
          else begin res = q[31:0]; inx = any; end
        end else begin
          lim = neg ? 64'h8000_0000 : 64'h7fff_ffff;
          if (q > lim) begin inv = 1; res = lim[31:0]; end
          else begin res = neg ? 32'(-q) : q[31:0]; inx = any; end
        end
      end else if (x[30:0] != 0) begin
        inx = 1;
        if (rm == 1 && !neg) res = 1;
        else if (rm == 2 && neg) begin
          if (sm) res = 32'hffff_ffff;
          else    inv = 1;
        end
      end
    end
    return {res, inv, inx, den};
  endfunction

  // reference sampled with the inputs the design captures
  always @(posedge clk) begin
    if (rst_n) begin
      exp_q.push_back(ref_cvt(f, is_signed, rmode, trunc));
      tag_q.push_back(cur_tag);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [34:0] w;
      string t;
      w = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if ({result, invalid, inexact, in_denorm} !== w) begin
        n_fail++;
        $display("FAIL %s: got res=%h inv=%b inx=%b den=%b, expected res=%h inv=%b inx=%b den=%b",
                 t, result, invalid, inexact, in_denorm, w[34:3], w[2], w[1], w[0]);
      end
    end
  end

  task automatic vec(input string tag, input logic [31:0] x, input logic s,
                     input logic [1:0] rm, input logic tr, input logic [31:0] want);
    @(negedge clk);
    cur_tag = tag; f = x; is_signed = s; rmode = rm; trunc = tr;
    @(posedge clk);
    @(negedge clk);
    #1;
    n_tests++;
    if (result !== want) begin
      n_fail++;
      $display("FAIL %s: got res=%h, expected res=%h", tag, result, want);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got no completion, expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; f = 32'h3fc0_0000; is_signed = 1'b1; rmode = 2'd0; trunc = 1'b0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (result !== 0 || invalid || inexact || in_denorm) begin
      n_fail++;
      $display("FAIL R1 reset: got res=%h flags=%b%b%b, expected 0 000", result, invalid, inexact, in_denorm);
    end
    rst_n = 1'b1;

    vec("R3 1.5 nearest tie up",       32'h3fc0_0000, 1, 2'd0, 0, 32'd2);
    vec("R3 2.5 nearest tie even",     32'h4020_0000, 1, 2'd0, 0, 32'd2);
    vec("R2 2.5 toward +inf",          32'h4020_0000, 1, 2'd1, 0, 32'd3);
    vec("R2 2.5 toward -inf",          32'h4020_0000, 1, 2'd2, 0, 32'd2);
    vec("R2 2.5 toward zero",          32'h4020_0000, 0, 2'd3, 0, 32'd2);
    vec("R2 trunc overrides +inf",     32'h4020_0000, 1, 2'd1, 1, 32'd2);
    vec("R3 -2.5 nearest",             32'hc020_0000, 1, 2'd0, 0, 32'hffff_fffe);
    vec("R3 -2.5 toward -inf",         32'hc020_0000, 1, 2'd2, 0, 32'hffff_fffd);
    vec("R4 exact 100.0",              32'h42c8_0000, 0, 2'd0, 0, 32'd100);
    vec("R5 R10 subnormal +inf",       32'h0000_0001, 1, 2'd1, 0, 32'd1);
    vec("R6 2^32 unsigned",            32'h4f80_0000, 0, 2'd0, 0, 32'hffff_ffff);
    vec("R6 2^32 signed",              32'h4f80_0000, 1, 2'd0, 0, 32'h7fff_ffff);
    vec("R6 -2^32 unsigned",           32'hcf80_0000, 0, 2'd0, 0, 32'h0);
    vec("R6 -inf signed",              32'hff80_0000, 1, 2'd0, 0, 32'h8000_0000);
    vec("R7 NaN signed",               32'h7fc0_0000, 1, 2'd0, 0, 32'h0);
    vec("R7 NaN unsigned",             32'h7fc0_0001, 0, 2'd0, 0, 32'hffff_ffff);
    vec("R7 negative NaN unsigned",    32'hffc0_0000, 0, 2'd2, 0, 32'hffff_ffff);
    vec("R8 -1.0 unsigned",            32'hbf80_0000, 0, 2'd0, 0, 32'h0);
    vec("R8 -0.75 unsigned nearest",   32'hbf40_0000, 0, 2'd0, 0, 32'h0);
    vec("R9 2^31 signed clamps",       32'h4f00_0000, 1, 2'd0, 0, 32'h7fff_ffff);
    vec("R9 -2^31 signed exact",       32'hcf00_0000, 1, 2'd0, 0, 32'h8000_0000);
    vec("R3 2^31 unsigned",            32'h4f00_0000, 0, 2'd0, 0, 32'h8000_0000);
    vec("R10 0.3 toward +inf",         32'h3e99_999a, 1, 2'd1, 0, 32'd1);
    vec("R10 -0.3 signed -inf",        32'hbe99_999a, 1, 2'd2, 0, 32'hffff_ffff);
    vec("R10 -0.3 unsigned -inf",      32'hbe99_999a, 0, 2'd2, 0, 32'h0);
    vec("R10 0.3 nearest",             32'h3e99_999a, 1, 2'd0, 0, 32'h0);
    vec("R3 0.75 nearest",             32'h3f40_0000, 1, 2'd0, 0, 32'd1);
    vec("R11 +0",                      32'h0000_0000, 0, 2'd1, 0, 32'h0);
    vec("R11 -0",                      32'h8000_0000, 1, 2'd2, 0, 32'h0);

    // random stream focused on exponents around the decision points
    cur_tag = "R3 R4 R9 random";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ex;
      @(negedge clk);
      case ($urandom_range(0, 9))
        0:       ex = 8'd0;
        1:       ex = 8'd255;
        default: ex = 8'(100 + $urandom_range(0, 70));
      endcase
      f = {1'($urandom), ex, 23'($urandom)};
      is_signed = 1'($urandom);
      rmode = 2'($urandom);
      trunc = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk);
    @(negedge clk);
    finish_up();
  end
endmodule